// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one external interrupt request pin into a clean, sticky interrupt event for a processor. The raw pin passes through a two-flop synchronizer. The synchronized value is then compared with its previous sample to find edges of a software-selected polarity. In an optional mode, the block also treats a persisting active level as a request. A sticky flag records each qualifying event. An interrupt enable gates that flag onto the request output. The block also drives the enable and direction controls for the pad's pull device.

Software reaches the block through one 8-bit status and control register. The register sits on a simple synchronous register bus made of an address, a write strobe, write data and combinational read data. Software enables the pin function, picks the polarity and the sensitivity mode, and polls or takes the interrupt. It then writes a 1 to the acknowledge bit to clear the flag. In edge-and-level mode, the flag cannot be cleared while the pin stays at its active level.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, every implemented register bit reads 0, and `irq_req`, `pull_en` and `pull_down` are 0. Bit 7 always reads 0, and a write to it has no effect. Register layout: bit 6 pull disable, bit 5 polarity, bit 4 pin enable, bit 3 flag, bit 2 acknowledge, bit 1 interrupt enable, bit 0 mode.
- R2: `reg_rdata` shows the register only while `reg_addr` equals `REG_ADDR`, and reads 0 otherwise. A write to any other address changes nothing.
- R3: While the pin enable (bit 4) is 0, no event sets the flag, and `pull_en` and `pull_down` are 0.
- R4: `pull_en` is 1 exactly when the pin enable is 1 and the pull disable (bit 6) is 0. `pull_down` is 1 exactly when `pull_en` is 1 and the polarity (bit 5) is 1.
- R5: With polarity 0, a falling edge of the pin sets the flag (bit 3). With polarity 1, a rising edge sets it. The flag rises at the third rising clock edge after the pin changes.
- R6: With mode 0 (edge only), a pin held at its active level does not set the flag again after an acknowledge.
- R7: With mode 1 (edge and level), the flag is set on every cycle the synchronized pin sits at the active level. An acknowledge therefore leaves the flag at 1 until the pin goes inactive.
- R8: Bit 2 always reads 0. Writing a 1 to it clears the flag on the next clock edge when no event occurs in that cycle. Writing a 0 to it leaves the flag unchanged.
- R9: When a qualifying event and an acknowledge write fall in the same cycle, the flag is 1 afterwards.
- R10: `irq_req` equals the flag ANDed with the interrupt enable (bit 1). The flag still sets while the interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous external request pin |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Register bus write strobe |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data |
| irq_req | output | 1 | Interrupt request to the processor |
| pull_en | output | 1 | Pad pull device enable |
| pull_down | output | 1 | Pad pull direction: 1 pulls down, 0 pulls up |

## Verification
The bench goes after the cycle where an acknowledge write and a fresh event coincide. A design that let the acknowledge win would drop an interrupt. It holds the pin at its active level across acknowledges in both modes. A level-mode design that cleared the flag would lose a pending request, and an edge-mode design that set the flag again would raise phantom interrupts. The bench also counts the three-cycle latency from the pin to the flag, which catches a missing or extra synchronizer stage. It checks the pull direction under both polarities, which catches a pad that pulls against the active level, and it checks that a disabled pin stays quiet.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int REG_W  = 8;
    localparam int B_PDIS = 6;
    localparam int B_POL  = 5;
    localparam int B_PEN  = 4;
    localparam int B_FLAG = 3;
    localparam int B_ACK  = 2;
    localparam int B_IE   = 1;
    localparam int B_MODE = 0;

    typedef enum logic {
        SENSE_EDGE       = 1'b0,
        SENSE_EDGE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        logic   pull_dis;
        logic   pol;
        logic   pin_en;
        logic   ie;
        sense_e sense;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{pull_dis: 1'b0, pol: 1'b0, pin_en: 1'b0,
                                     ie: 1'b0, sense: SENSE_EDGE};

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] d);
        ctrl_t c;
        c.pull_dis = d[B_PDIS];
        c.pol      = d[B_POL];
        c.pin_en   = d[B_PEN];
        c.ie       = d[B_IE];
        c.sense    = sense_e'(d[B_MODE]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input ctrl_t c, input logic flag);
        logic [REG_W-1:0] r;
        r         = '0;
        r[B_PDIS] = c.pull_dis;
        r[B_POL]  = c.pol;
        r[B_PEN]  = c.pin_en;
        r[B_FLAG] = flag;
        r[B_IE]   = c.ie;
        r[B_MODE] = c.sense;
        return r;
    endfunction

    function automatic logic is_active(input logic level, input logic pol);
        return level == pol;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_sync,
    input  ctrl_t ctrl,
    output logic  event_o
);
    logic prev_q;
    logic rise, fall, edge_hit, level_hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_sync;
    end

    always_comb begin
        rise      = pin_sync & ~prev_q;
        fall      = ~pin_sync & prev_q;
        edge_hit  = ctrl.pol ? rise : fall;
        level_hit = (ctrl.sense == SENSE_EDGE_LEVEL) && is_active(pin_sync, ctrl.pol);
        event_o   = ctrl.pin_en & (edge_hit | level_hit);
    end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              event_i,
    output logic [REG_W-1:0]  reg_rdata,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic              ack_pulse
);
    logic hit, wr_hit;

    always_comb begin
        hit       = (reg_addr == REG_ADDR);
        wr_hit    = hit & reg_wr;
        ack_pulse = wr_hit & reg_wdata[B_ACK];
        reg_rdata = hit ? pack_status(ctrl, flag) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         ctrl <= CTRL_RESET;
        else if (wr_hit) ctrl <= unpack_ctrl(reg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (event_i)   flag <= 1'b1;
        else if (ack_pulse) flag <= 1'b0;
    end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h14,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_req,
    output logic              pull_en,
    output logic              pull_down
);
    logic  pin_sync;
    logic  det_event;
    logic  flag;
    logic  ack_pulse;
    ctrl_t ctrl;

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    xirq_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync),
        .ctrl     (ctrl),
        .event_o  (det_event)
    );

    xirq_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .event_i   (det_event),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl),
        .flag      (flag),
        .ack_pulse (ack_pulse)
    );

    always_comb begin
        irq_req   = flag & ctrl.ie;
        pull_en   = ctrl.pin_en & ~ctrl.pull_dis;
        pull_down = pull_en & ctrl.pol;
    end
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk (
    input logic clk,
    input logic rst,
    input logic event_i,
    input logic ack_i,
    input logic flag_i,
    input logic pe_i,
    input logic mode_i,
    input logic pol_i,
    input logic ie_i,
    input logic sync_i,
    input logic irq_req,
    input logic pull_en,
    input logic pull_down
);
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        event_i |=> flag_i); // R5
    AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (event_i && ack_i) |=> flag_i); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !event_i) |=> !flag_i); // R8
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!pe_i && !flag_i) |=> !flag_i); // R3
    AST_OFF_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        !pe_i |-> !pull_en); // R3
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pe_i && mode_i && (sync_i == pol_i)) |=> flag_i); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (flag_i && ie_i)); // R10
    AST_PULL_DIR: assert property (@(posedge clk) disable iff (rst)
        pull_down |-> pull_en); // R4
endmodule

bind xirq_ctrl xirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .event_i   (det_event),
    .ack_i     (ack_pulse),
    .flag_i    (flag),
    .pe_i      (ctrl.pin_en),
    .mode_i    (ctrl.sense),
    .pol_i     (ctrl.pol),
    .ie_i      (ctrl.ie),
    .sync_i    (pin_sync),
    .irq_req   (irq_req),
    .pull_en   (pull_en),
    .pull_down (pull_down)
);

// File: tb/tb_xirq_ctrl.sv
module tb_xirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RA = 8'h14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_in = 1'b0;
    logic [7:0] reg_addr = RA;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_req, pull_en, pull_down;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    xirq_ctrl dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .pull_en(pull_en), .pull_down(pull_down)
    );

    // reference state, built from the requirements
    logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_flag = 0;
    logic m_pdis = 0, m_pol = 0, m_pen = 0, m_ie = 0, m_mode = 0;

    function automatic logic m_event();
        logic edge_ok, lvl_ok;
        edge_ok = m_pol ? (m_s2 & ~m_prev) : (~m_s2 & m_prev);
        lvl_ok  = m_mode & (m_s2 == m_pol);
        return m_pen & (edge_ok | lvl_ok);
    endfunction

    function automatic logic [7:0] m_rdata();
        if (reg_addr != RA) return 8'h00;
        return {1'b0, m_pdis, m_pol, m_pen, m_flag, 1'b0, m_ie, m_mode};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
            m_pdis <= 0; m_pol <= 0; m_pen <= 0; m_ie <= 0; m_mode <= 0;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
            if (m_event()) m_flag <= 1'b1;
            else if (reg_wr && reg_addr == RA && reg_wdata[2]) m_flag <= 1'b0;
            if (reg_wr && reg_addr == RA) begin
                m_pdis <= reg_wdata[6]; m_pol <= reg_wdata[5]; m_pen <= reg_wdata[4];
                m_ie <= reg_wdata[1]; m_mode <= reg_wdata[0];
            end
        end
    end

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic pe_exp;
        pe_exp = m_pen & ~m_pdis;
        check("rdata", reg_rdata, m_rdata());
        check("irq_req", {7'b0, irq_req}, {7'b0, m_flag & m_ie});
        check("pull_en", {7'b0, pull_en}, {7'b0, pe_exp});
        check("pull_down", {7'b0, pull_down}, {7'b0, pe_exp & m_pol});
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b0;
            check_all();
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_addr = RA; reg_wdata = d; reg_wr = 1'b1;
        step();
    endtask

    task automatic flag_is(input logic v);
        check("flag", {7'b0, reg_rdata[3]}, {7'b0, v});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        @(negedge clk);
        check("reset rdata", reg_rdata, 8'h00);
        check_all();
        wr(8'h80);
        check("bit7 ignored", reg_rdata, 8'h00);
        // R2 address decode
        cur_req = "R2";
        reg_addr = RA + 1; reg_wdata = 8'h13; reg_wr = 1'b1;
        step();
        check("other addr read", reg_rdata, 8'h00);
        reg_addr = RA; #1;
        check("other addr write ignored", reg_rdata, 8'h00);
        // R3 disabled pin: edges ignored, no pull
        cur_req = "R3";
        wr(8'h01);
        pin_in = 1; step(4); pin_in = 0; step(4);
        flag_is(0);
        check("no pull", {6'b0, pull_en, pull_down}, 8'h00);
        // R4 pull controls
        cur_req = "R4";
        wr(8'h10); check("pull up", {6'b0, pull_en, pull_down}, 8'h02);
        wr(8'h30); check("pull down", {6'b0, pull_en, pull_down}, 8'h03);
        wr(8'h70); check("pull off", {6'b0, pull_en, pull_down}, 8'h00);
        // R5 falling edge, latency 3 edges
        cur_req = "R5";
        pin_in = 1; wr(8'h10); step(4);
        wr(8'h14);
        flag_is(0);
        pin_in = 0;
        step(2); flag_is(0);
        step(1); flag_is(1);
        // R8 ack clears, ack 0 keeps, ack reads 0
        cur_req = "R8";
        wr(8'h10); flag_is(1);
        wr(8'h14); flag_is(0);
        check("ack reads 0", {7'b0, reg_rdata[2]}, 8'h00);
        // R5 rising edge
        cur_req = "R5";
        wr(8'h30); pin_in = 1; step(3); flag_is(1);
        // R6 edge mode: held level does not re-set
        cur_req = "R6";
        wr(8'h34); step(5); flag_is(0);
        // R7 level mode: ack while active keeps flag
        cur_req = "R7";
        wr(8'h31); step(1); flag_is(1);
        wr(8'h35); flag_is(1);
        pin_in = 0; step(4);
        wr(8'h35); flag_is(0);
        // R9 event and ack together
        cur_req = "R9";
        wr(8'h30); pin_in = 1; step(2);
        wr(8'h34); flag_is(1);
        // R10 irq gated by enable
        cur_req = "R10";
        check("irq off", {7'b0, irq_req}, 8'h00);
        wr(8'h32); check("irq on", {7'b0, irq_req}, 8'h01);
        // random phase, model compares every cycle
        cur_req = "R5";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 5) == 0) pin_in = ~pin_in;
            reg_wr = ($urandom_range(0, 7) == 0);
            reg_addr = ($urandom_range(0, 9) == 0) ? 8'h15 : RA;
            reg_wdata = 8'($urandom);
            if ($urandom_range(0, 2) != 0) reg_wdata[4] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b0;
            check_all();
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule